// File: doc/BRIEF.md
# Compact-flash sector read sequencer

This block is a bus master that pulls a run of 512-byte sectors out of a compact-flash controller through that controller's 16-bit register window. The controller's register port is a single-outstanding request/acknowledge port. A one-cycle `start` carries a 28-bit starting LBA and a sector count. The block then takes the controller's arbitration lock and waits for the card to report ready. It issues read commands in chunks of at most 256 sectors and drains the controller's data buffer in 16-word bursts. The data leaves on a valid/ready byte stream. When the run ends, the lock is handed back and `done` pulses with an error flag and a code.

Register offsets on the controller side are fixed by the controller: status at 0x04, LBA low at 0x10, LBA high at 0x12, count/command at 0x14, control at 0x18 and the data buffer at 0x40. Every change to the control register is a read-modify-write that starts from the value actually read back. All poll spacings and retry limits are parameters counted in clock cycles.

Top module: `cf_sector_reader`

## Requirements
- R1: A start with a count of 0 raises `done` (with `err` low) in the cycle after `start` is sampled, and makes no register request.
- R2: To take the lock, the block reads the control register (0x18) and writes it back with bit 1 set and all other bits unchanged. It then reads the status register (0x04) until status bit 1 (lock granted) is 1.
- R3: If the grant is not seen within LOCK_TRIES status reads, spaced at least LOCK_GAP cycles apart, the run ends with `err`. `err_code` is 2 (held by another master) when status bit 4 (card present) was 1 in the last read, or 1 (card absent) when it was 0. No further write is made.
- R4: Once the lock is held, status is read until bit 8 (ready for command) is 1, for at most RDY_TRIES reads. If bit 4 reads 0 first, the run ends with code 1. If the reads run out, it ends with code 3. In both cases the lock is first released by a read-modify-write that clears control bit 1.
- R5: The request is split into chunks of min(remaining, CHUNK_MAX) sectors. Each chunk writes LBA[15:0] to 0x10, then {4'h0, LBA[27:16]} to 0x12.
- R6: Each chunk then writes 0x14 with 0x03 in bits 15:8 and the chunk size in bits 7:0. A chunk of 256 is encoded as 0x00.
- R7: After the command write, control bit 7 is set by read-modify-write. After the chunk's last data word, it is cleared the same way.
- R8: A chunk is drained as chunk x BURSTS_PER_SECTOR bursts. Each burst follows a status read with bit 5 (buffer ready) equal to 1, and consists of exactly 16 reads of 0x40.
- R9: Each data word leaves as two bytes, bits 7:0 first and bits 15:8 second. While `out_valid` is high and `out_ready` is low, the byte is held and nothing is dropped.
- R10: After each chunk the LBA advances and the remaining count falls by the chunk size. At zero the lock is released (control bit 1 cleared) and `done` pulses with `err` low and `err_code` 0.
- R11: A register request keeps `reg_addr`, `reg_we` and `reg_wdata` stable until the cycle in which `reg_ack` is high.
- R12: `start` is ignored while `busy`. `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken only when idle) |
| start_lba | input | 28 | First sector address |
| start_count | input | CNT_W | Number of sectors |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Run failed (valid with done) |
| err_code | output | 2 | 0 ok, 1 card absent, 2 lock held elsewhere, 3 not ready |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | Access is a write |
| reg_addr | output | 8 | Register byte offset |
| reg_wdata | output | 16 | Write data |
| reg_rdata | input | 16 | Read data, valid with reg_ack |
| reg_ack | input | 1 | Access completes in this cycle |
| out_valid | output | 1 | Byte available |
| out_data | output | 8 | Byte value |
| out_ready | input | 1 | Sink takes the byte |

## Verification
Most faults in this sequencer show up first on the register port. A wrong chunk size, a wrong LBA carry, or a lost read-modify-write value appears as a mismatched write on the first access after the fault, long before any data is missing. A burst counter or word counter that goes wrong shows up in the byte stream instead. Either a data read arrives that no buffer-ready status granted, or the total byte count at `done` is off. The order of the low and high bytes, and the holding of a byte under backpressure, are compared on every accepted byte.

// File: rtl/cf_sector_reader.sv
module cf_sector_reader #(
  parameter int CNT_W             = 16,
  parameter int CHUNK_MAX         = 256,
  parameter int BURST_WORDS       = 16,
  parameter int BURSTS_PER_SECTOR = 16,
  parameter int LOCK_TRIES        = 12,
  parameter int LOCK_GAP          = 10_000_000,
  parameter int RDY_TRIES         = 2001,
  parameter int RDY_GAP           = 100_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [27:0]      start_lba,
  input  logic [CNT_W-1:0] start_count,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [1:0]       err_code,
  output logic             reg_req,
  output logic             reg_we,
  output logic [7:0]       reg_addr,
  output logic [15:0]      reg_wdata,
  input  logic [15:0]      reg_rdata,
  input  logic             reg_ack,
  output logic             out_valid,
  output logic [7:0]       out_data,
  input  logic             out_ready
);
  localparam int TRY_MAX = (LOCK_TRIES > RDY_TRIES) ? LOCK_TRIES : RDY_TRIES;
  localparam int GAP_MAX = (LOCK_GAP > RDY_GAP) ? LOCK_GAP : RDY_GAP;
  localparam int TRY_W   = $clog2(TRY_MAX + 1);
  localparam int GAP_W   = $clog2(GAP_MAX + 1);
  localparam int WIDX_W  = (BURST_WORDS > 1) ? $clog2(BURST_WORDS) : 1;
  localparam int BRST_W  = $clog2(CHUNK_MAX * BURSTS_PER_SECTOR + 1);

  localparam logic [TRY_W-1:0]  LOCK_LAST = TRY_W'(LOCK_TRIES - 1);
  localparam logic [TRY_W-1:0]  RDY_LAST  = TRY_W'(RDY_TRIES - 1);
  localparam logic [GAP_W-1:0]  LGAP_LAST = GAP_W'(LOCK_GAP - 1);
  localparam logic [GAP_W-1:0]  RGAP_LAST = GAP_W'(RDY_GAP - 1);
  localparam logic [WIDX_W-1:0] WORD_LAST = WIDX_W'(BURST_WORDS - 1);

  localparam logic [7:0] A_STAT = 8'h04;
  localparam logic [7:0] A_LBLO = 8'h10;
  localparam logic [7:0] A_LBHI = 8'h12;
  localparam logic [7:0] A_CMD  = 8'h14;
  localparam logic [7:0] A_CTRL = 8'h18;
  localparam logic [7:0] A_DATA = 8'h40;

  localparam logic [1:0] E_NONE = 2'd0;
  localparam logic [1:0] E_CARD = 2'd1;
  localparam logic [1:0] E_HELD = 2'd2;
  localparam logic [1:0] E_NRDY = 2'd3;

  typedef enum logic [4:0] {
    S_IDLE, S_LK_RD, S_LK_WR, S_LK_POLL, S_LK_WAIT, S_RY_POLL, S_RY_WAIT,
    S_CH_LO, S_CH_HI, S_CH_CMD, S_RS_RD, S_RS_WR, S_BF_POLL, S_DT_RD,
    S_EM_LO, S_EM_HI, S_UR_RD, S_UR_WR, S_RL_RD, S_RL_WR, S_FIN
  } state_t;

  state_t             state;
  logic [27:0]        lba;
  logic [CNT_W-1:0]   remain;
  logic [CNT_W-1:0]   chunk_now;
  logic [BRST_W-1:0]  bursts_left;
  logic [WIDX_W-1:0]  widx;
  logic [TRY_W-1:0]   tries;
  logic [GAP_W-1:0]   gap;
  logic [15:0]        shadow;
  logic [1:0]         code;
  logic               xfer;

  assign chunk_now = (remain > CNT_W'(CHUNK_MAX)) ? CNT_W'(CHUNK_MAX) : remain;
  assign xfer      = reg_req && reg_ack;
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_FIN);
  assign err       = done && (code != E_NONE);
  assign err_code  = code;
  assign out_valid = (state == S_EM_LO) || (state == S_EM_HI);
  assign out_data  = (state == S_EM_HI) ? shadow[15:8] : shadow[7:0];

  always_comb begin
    reg_req   = 1'b1;
    reg_we    = 1'b0;
    reg_addr  = A_CTRL;
    reg_wdata = 16'h0000;
    case (state)
      S_LK_RD, S_RS_RD, S_UR_RD, S_RL_RD: ;
      S_LK_WR: begin reg_we = 1'b1; reg_wdata = shadow | 16'h0002; end
      S_RS_WR: begin reg_we = 1'b1; reg_wdata = shadow | 16'h0080; end
      S_UR_WR: begin reg_we = 1'b1; reg_wdata = shadow & 16'hFF7F; end
      S_RL_WR: begin reg_we = 1'b1; reg_wdata = shadow & 16'hFFFD; end
      S_LK_POLL, S_RY_POLL, S_BF_POLL: reg_addr = A_STAT;
      S_CH_LO: begin reg_we = 1'b1; reg_addr = A_LBLO; reg_wdata = lba[15:0]; end
      S_CH_HI: begin reg_we = 1'b1; reg_addr = A_LBHI; reg_wdata = {4'h0, lba[27:16]}; end
      S_CH_CMD: begin reg_we = 1'b1; reg_addr = A_CMD; reg_wdata = {8'h03, chunk_now[7:0]}; end
      S_DT_RD: reg_addr = A_DATA;
      default: reg_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      lba         <= '0;
      remain      <= '0;
      bursts_left <= '0;
      widx        <= '0;
      tries       <= '0;
      gap         <= '0;
      shadow      <= '0;
      code        <= E_NONE;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          lba    <= start_lba;
          remain <= start_count;
          code   <= E_NONE;
          tries  <= '0;
          state  <= (start_count == '0) ? S_FIN : S_LK_RD;
        end
        S_LK_RD: if (xfer) begin shadow <= reg_rdata; state <= S_LK_WR; end
        S_LK_WR: if (xfer) state <= S_LK_POLL;
        S_LK_POLL: if (xfer) begin
          if (reg_rdata[1]) begin
            tries <= '0;
            state <= S_RY_POLL;
          end else if (tries == LOCK_LAST) begin
            code  <= reg_rdata[4] ? E_HELD : E_CARD;
            state <= S_FIN;
          end else begin
            tries <= tries + 1'b1;
            gap   <= '0;
            state <= S_LK_WAIT;
          end
        end
        S_LK_WAIT: begin
          gap <= gap + 1'b1;
          if (gap == LGAP_LAST) state <= S_LK_POLL;
        end
        S_RY_POLL: if (xfer) begin
          if (!reg_rdata[4]) begin
            code  <= E_CARD;
            state <= S_RL_RD;
          end else if (reg_rdata[8]) begin
            state <= S_CH_LO;
          end else if (tries == RDY_LAST) begin
            code  <= E_NRDY;
            state <= S_RL_RD;
          end else begin
            tries <= tries + 1'b1;
            gap   <= '0;
            state <= S_RY_WAIT;
          end
        end
        S_RY_WAIT: begin
          gap <= gap + 1'b1;
          if (gap == RGAP_LAST) state <= S_RY_POLL;
        end
        S_CH_LO: if (xfer) state <= S_CH_HI;
        S_CH_HI: if (xfer) state <= S_CH_CMD;
        S_CH_CMD: if (xfer) begin
          bursts_left <= BRST_W'(chunk_now * BURSTS_PER_SECTOR);
          state       <= S_RS_RD;
        end
        S_RS_RD: if (xfer) begin shadow <= reg_rdata; state <= S_RS_WR; end
        S_RS_WR: if (xfer) state <= S_BF_POLL;
        S_BF_POLL: if (xfer && reg_rdata[5]) begin
          widx  <= '0;
          state <= S_DT_RD;
        end
        S_DT_RD: if (xfer) begin shadow <= reg_rdata; state <= S_EM_LO; end
        S_EM_LO: if (out_ready) state <= S_EM_HI;
        S_EM_HI: if (out_ready) begin
          if (widx != WORD_LAST) begin
            widx  <= widx + 1'b1;
            state <= S_DT_RD;
          end else begin
            bursts_left <= bursts_left - 1'b1;
            state       <= (bursts_left == BRST_W'(1)) ? S_UR_RD : S_BF_POLL;
          end
        end
        S_UR_RD: if (xfer) begin shadow <= reg_rdata; state <= S_UR_WR; end
        S_UR_WR: if (xfer) begin
          lba    <= lba + 28'(chunk_now);
          remain <= remain - chunk_now;
          state  <= (remain == chunk_now) ? S_RL_RD : S_CH_LO;
        end
        S_RL_RD: if (xfer) begin shadow <= reg_rdata; state <= S_RL_WR; end
        S_RL_WR: if (xfer) state <= S_FIN;
        S_FIN: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module cf_sector_reader_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CNT_W-1:0] start_count,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic             reg_req,
  input logic             reg_we,
  input logic [7:0]       reg_addr,
  input logic [15:0]      reg_wdata,
  input logic             reg_ack,
  input logic             out_valid,
  input logic [7:0]       out_data,
  input logic             out_ready
);
  p_zero_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && start_count == '0 |=> done && !err && !reg_req);

  p_cmd_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && reg_we && reg_addr == 8'h14 |-> reg_wdata[15:8] == 8'h03);

  p_lba_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && reg_we && reg_addr == 8'h12 |-> reg_wdata[15:12] == 4'h0);

  p_byte_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_ack |=> reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind cf_sector_reader cf_sector_reader_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_count(start_count),
  .busy(busy), .done(done), .err(err), .reg_req(reg_req), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack),
  .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
);

// File: tb/sim_cf_sector_reader.sv
module sim_cf_sector_reader;
  localparam int LT  = 4;
  localparam int LG  = 20;
  localparam int RT  = 5;
  localparam int RG  = 8;
  localparam int BPS = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [27:0] start_lba = '0;
  logic [15:0] start_count = '0;
  logic        busy, done, err;
  logic [1:0]  err_code;
  logic        reg_req, reg_we, reg_ack;
  logic [7:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        out_valid, out_ready;
  logic [7:0]  out_data;

  always #5 clk = ~clk;

  cf_sector_reader #(
    .CHUNK_MAX(256), .BURSTS_PER_SECTOR(BPS), .LOCK_TRIES(LT), .LOCK_GAP(LG),
    .RDY_TRIES(RT), .RDY_GAP(RG)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_lba(start_lba),
    .start_count(start_count), .busy(busy), .done(done), .err(err),
    .err_code(err_code), .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  // scenario configuration, written only by the main process
  int          cfg_seq = 0;
  logic [15:0] cfg_ctrl = '0;
  bit          cfg_card = 1'b0;
  int          cfg_off = -1, cfg_grant = -1, cfg_ready = -1;
  int          n_exp = 0;
  logic [23:0] exp_w [0:31];
  bit          no_bus = 1'b0;
  bit          all_done = 1'b0;

  // reference card controller and stream monitor state
  int          seen_seq = 0, mon_checks = 0, mon_errors = 0;
  int          cyc = 0, wi = 0, stat_reads = 0, credit = 0, dreads = 0, nbytes = 0;
  int          lat = 0, wcnt = 0, first_stat = 0, last_stat = 0;
  logic [15:0] ctrl = '0;
  bit          pending = 1'b0, stall_p = 1'b0;
  logic [7:0]  paddr = '0, pbyte = '0, lfsr = 8'h5A;
  logic        pwe = 1'b0;
  logic [15:0] pwd = '0;

  int tb_checks = 0, tb_errors = 0;

  task automatic chk_m(bit ok, string tag, int act, int exp);
    mon_checks++;
    if (!ok) begin
      mon_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_t(bit ok, string tag, int act, int exp);
    tb_checks++;
    if (!ok) begin
      tb_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      reg_ack   = 1'b0;
      reg_rdata = '0;
      out_ready = 1'b0;
    end else begin
      if (cfg_seq != seen_seq) begin
        seen_seq = cfg_seq;
        ctrl = cfg_ctrl; wi = 0; stat_reads = 0; credit = 0; dreads = 0; nbytes = 0;
      end
      if (pending)
        chk_m(reg_req && reg_addr == paddr && reg_we == pwe && reg_wdata == pwd,
              "R11 request held until ack", {reg_req, reg_addr}, {1'b1, paddr});
      if (stall_p)
        chk_m(out_valid && out_data == pbyte, "R9 byte held under stall", out_data, pbyte);
      if (no_bus)
        chk_m(!reg_req, "R1 no register access", reg_req, 0);

      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = lfsr[0] | lfsr[2];
      if (out_valid && out_ready) begin
        logic [15:0] w;
        w = 16'hA000 + 16'(nbytes >> 1);
        chk_m(out_data == (nbytes[0] ? w[15:8] : w[7:0]), "R9 byte order", out_data,
              nbytes[0] ? w[15:8] : w[7:0]);
        nbytes++;
      end
      stall_p = out_valid && !out_ready;
      pbyte   = out_data;

      reg_ack = 1'b0;
      if (reg_req) begin
        if (wcnt >= lat) begin
          reg_ack = 1'b1;
          wcnt = 0;
          lat = (lat + 1) % 3;
          if (reg_we) begin
            if (wi >= n_exp) chk_m(1'b0, "R2 unexpected write", {reg_addr, reg_wdata}, 0);
            else begin
              chk_m(exp_w[wi] == {reg_addr, reg_wdata}, "R2/R5/R6/R7/R10 write sequence",
                    {reg_addr, reg_wdata}, exp_w[wi]);
              wi++;
            end
            if (reg_addr == 8'h18) ctrl = reg_wdata;
          end else begin
            case (reg_addr)
              8'h18: reg_rdata = ctrl;
              8'h04: begin
                int i;
                bit cd, lk, rd, bf;
                i  = stat_reads;
                cd = cfg_card && !(cfg_off >= 0 && i >= cfg_off);
                lk = ctrl[1] && cfg_grant >= 0 && i >= cfg_grant;
                rd = lk && cfg_ready >= 0 && i >= cfg_ready;
                bf = rd && i > cfg_ready && ((i - cfg_ready) % 2 == 0);
                if (bf) credit = 16;
                reg_rdata = '0;
                reg_rdata[1] = lk; reg_rdata[4] = cd; reg_rdata[5] = bf; reg_rdata[8] = rd;
                if (i == 0) first_stat = cyc;
                last_stat = cyc;
                stat_reads++;
              end
              8'h40: begin
                chk_m(credit > 0, "R8 data read without buffer ready", credit, 1);
                credit--;
                reg_rdata = 16'hA000 + 16'(dreads);
                dreads++;
              end
              default: reg_rdata = '0;
            endcase
          end
        end else wcnt++;
      end else wcnt = 0;
      pending = reg_req && !reg_ack;
      paddr = reg_addr; pwe = reg_we; pwd = reg_wdata;
    end
  end

  task automatic setup(logic [15:0] c0, bit card, int off, int grant, int rdy);
    cfg_ctrl = c0; cfg_card = card; cfg_off = off; cfg_grant = grant; cfg_ready = rdy;
    n_exp = 0;
    cfg_seq++;
    repeat (2) @(negedge clk);
  endtask

  task automatic expw(logic [7:0] a, logic [15:0] d);
    exp_w[n_exp] = {a, d};
    n_exp++;
  endtask

  task automatic go(logic [27:0] lba, logic [15:0] cnt, int poke,
                    output bit e, output logic [1:0] code, output int dur);
    start_lba = lba; start_count = cnt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dur = 0;
    while (!done && cyc < 150000) begin
      @(negedge clk);
      dur++;
      if (poke > 0 && dur == poke) begin
        start = 1'b1; start_lba = 28'h1234567; start_count = 16'd5;
      end else start = 1'b0;
    end
    e = err; code = err_code;
    @(negedge clk);
    start = 1'b0;
    chk_t(!done, "R12 done is one cycle", done, 0);
    @(negedge clk);
  endtask

  initial begin
    bit e;
    logic [1:0] code;
    int dur;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_t(!busy && !done && !reg_req && !out_valid && err_code == 2'd0,
          "R12 reset state", {busy, done, reg_req, out_valid}, 0);

    // zero count
    setup(16'h4001, 1'b1, -1, 0, 0);
    no_bus = 1'b1;
    go(28'h0000055, 16'd0, 0, e, code, dur);
    chk_t(dur == 0, "R1 done one cycle after start", dur, 0);
    chk_t(!e, "R1 no error on empty run", e, 0);
    repeat (3) @(negedge clk);
    no_bus = 1'b0;

    // three sectors, late grant, start poked while busy
    setup(16'h4001, 1'b1, -1, 2, 4);
    expw(8'h18, 16'h4003);
    expw(8'h10, 16'hDEF1); expw(8'h12, 16'h0ABC); expw(8'h14, 16'h0303);
    expw(8'h18, 16'h4083); expw(8'h18, 16'h4003);
    expw(8'h18, 16'h4001);
    go(28'hABCDEF1, 16'd3, 40, e, code, dur);
    chk_t(!e && code == 2'd0, "R10 clean completion", code, 0);
    chk_t(nbytes == 3 * BPS * 32, "R8 byte total", nbytes, 3 * BPS * 32);
    chk_t(wi == n_exp, "R12 poked start ignored, writes complete", wi, n_exp);
    chk_t(ctrl == 16'h4001, "R10 lock released", ctrl, 16'h4001);

    // 300 sectors: full chunk encoded as 0, carry into LBA high half
    setup(16'h4001, 1'b1, -1, 0, 0);
    expw(8'h18, 16'h4003);
    expw(8'h10, 16'hFF80); expw(8'h12, 16'h0012); expw(8'h14, 16'h0300);
    expw(8'h18, 16'h4083); expw(8'h18, 16'h4003);
    expw(8'h10, 16'h0080); expw(8'h12, 16'h0013); expw(8'h14, 16'h032C);
    expw(8'h18, 16'h4083); expw(8'h18, 16'h4003);
    expw(8'h18, 16'h4001);
    go(28'h012FF80, 16'd300, 0, e, code, dur);
    chk_t(!e && code == 2'd0, "R5 chunked run completes", code, 0);
    chk_t(nbytes == 300 * BPS * 32, "R6 byte total over two chunks", nbytes, 300 * BPS * 32);
    chk_t(wi == n_exp, "R10 all chunk writes seen", wi, n_exp);

    // lock never granted, card present
    setup(16'h0000, 1'b1, -1, -1, -1);
    expw(8'h18, 16'h0002);
    go(28'h0000010, 16'd2, 0, e, code, dur);
    chk_t(e && code == 2'd2, "R3 lock held elsewhere", code, 2);
    chk_t(stat_reads == LT, "R3 lock poll count", stat_reads, LT);
    chk_t(last_stat - first_stat >= (LT - 1) * LG, "R3 lock poll spacing",
          last_stat - first_stat, (LT - 1) * LG);
    chk_t(wi == n_exp, "R3 no release write", wi, n_exp);

    // lock never granted, no card
    setup(16'h0000, 1'b0, -1, -1, -1);
    expw(8'h18, 16'h0002);
    go(28'h0000010, 16'd2, 0, e, code, dur);
    chk_t(e && code == 2'd1, "R3 card absent", code, 1);

    // never ready
    setup(16'h4001, 1'b1, -1, 0, -1);
    expw(8'h18, 16'h4003); expw(8'h18, 16'h4001);
    go(28'h0000020, 16'd1, 0, e, code, dur);
    chk_t(e && code == 2'd3, "R4 not ready timeout", code, 3);
    chk_t(stat_reads == 1 + RT, "R4 ready poll count", stat_reads, 1 + RT);
    chk_t(wi == n_exp && ctrl == 16'h4001, "R4 release after timeout", ctrl, 16'h4001);

    // card pulled while waiting for ready
    setup(16'h4001, 1'b1, 2, 0, -1);
    expw(8'h18, 16'h4003); expw(8'h18, 16'h4001);
    go(28'h0000020, 16'd1, 0, e, code, dur);
    chk_t(e && code == 2'd1, "R4 card lost during ready wait", code, 1);
    chk_t(stat_reads == 3, "R4 stops at card loss", stat_reads, 3);
    chk_t(wi == n_exp && ctrl == 16'h4001, "R4 release after card loss", ctrl, 16'h4001);

    all_done = 1'b1;
    $display("Result: errors=%0d of %0d checks", tb_errors + mon_errors, tb_checks + mon_checks);
    $finish;
  end

  initial begin
    repeat (160000) @(negedge clk);
    if (!all_done) begin
      $display("FAIL R12 watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", tb_errors + mon_errors + 1,
               tb_checks + mon_checks + 1);
      $finish;
    end
  end
endmodule